// File: doc/BRIEF.md
# Receive Byte Buffer with Single-Register Bypass

This block sits on the receive side of a serial port, between the deserializer and the register interface that software reads. The deserializer hands over each finished byte with a one-cycle valid strobe. A mode input selects how the bytes are stored. With the mode input high they go into a multi-entry first-in first-out queue. With it low they go into a one-byte holding register. Software always takes bytes from the same data output, whichever mode is active. It also watches an empty flag, a full flag, a sticky overrun flag and a receive interrupt status bit.

Every strobe on the data-register read input counts as a consuming access, even when it was meant only for inspection. In queue mode such a read removes the oldest byte. In holding mode it empties the holding register and also clears the receive interrupt status. A change of the mode input flushes whatever is stored. A write strobe to the clear register, together with a bit mask, drops the sticky flags.

Top module: `rxq_buffer`

## Requirements
- R1: After reset, empty is 1, full is 0, overrun is 0, the interrupt status is 0 and the data output is 0x00.
- R2: In queue mode (mode input 1), bytes come out of the data output in the order they arrived, and up to DEPTH (16) bytes are kept.
- R3: The empty flag is 0 while at least one byte is stored in the active buffer and 1 when none is. It changes in the cycle after the push or pop that causes the change.
- R4: The full flag is 1 when DEPTH bytes are stored in queue mode, or when one byte is stored in holding mode (mode input 0). Otherwise it is 0.
- R5: A read strobe while data is stored removes the oldest byte, and that byte appears on the data output one clock after the strobe.
- R6: In holding mode, a read strobe while a byte is held clears the interrupt status. In queue mode, a read leaves the interrupt status unchanged.
- R7: A byte that arrives while the buffer is full is dropped, even if a read happens in the same cycle, and the overrun flag is set. The flag stays set until a clear-register write with mask bit 0 set. If a new overrun and such a clear fall in the same cycle, the overrun wins.
- R8: The interrupt status is set when a byte is accepted into an empty buffer, in either mode. A clear-register write with mask bit 1 set clears it, and a new set wins over the clear in the same cycle.
- R9: In a cycle where the mode input differs from its value in the previous cycle (the previous value is taken as 0 at reset), the stored bytes are discarded and the interrupt status is cleared. Any byte strobe or read strobe in that cycle is ignored, so empty reads 1 afterwards.
- R10: A read strobe while the buffer is empty keeps the data output at its last value and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1 = multi-entry queue, 0 = one-byte holding register |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is on rx_byte_i |
| rx_byte_i | input | WIDTH | Received byte |
| rd_strobe_i | input | 1 | Data-register read access, one cycle per read |
| clr_we_i | input | 1 | Write strobe of the clear register |
| clr_mask_i | input | 2 | Clear mask: bit 0 clears overrun, bit 1 clears the interrupt status |
| rd_data_o | output | WIDTH | Data-register value, the most recently read byte |
| empty_o | output | 1 | Active buffer holds no byte |
| full_o | output | 1 | Active buffer is at capacity |
| overrun_o | output | 1 | Sticky: a byte was dropped |
| rx_irq_o | output | 1 | Receive interrupt status |

## Verification
Holding mode is tried with a single byte, with a second byte arriving while the first is still held, and with reads of an empty register. Together these show whether capacity is one, whether the read clears the interrupt, and whether an empty read changes anything. Queue mode is filled past sixteen bytes and then drained, which checks that the order is kept, that full is raised at the correct count and that the overflowing byte is dropped; it also shows that reads do not clear the interrupt there. Pushes and pops in the same cycle, mode flips while bytes are stored, and a long pseudo-random mix of strobes are compared cycle by cycle against a queue model. This catches errors in flush handling and in the same-cycle priority between set and clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned CLR_OVR_BIT = 0;
   localparam int unsigned CLR_IRQ_BIT = 1;
   localparam int unsigned CLR_W       = 2;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             deep_i,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] head_o,
   output logic             empty_o,
   output logic             full_o
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit          POW2 = (DEPTH == (1 << AW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_store: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("rxq_store: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0]    count, cap;

   generate
      if (POW2) begin : g_wrap_free
         assign wptr_nx = wptr + AW'(1);
         assign rptr_nx = rptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
   endgenerate

   assign cap     = deep_i ? CW'(DEPTH) : CW'(1);
   assign empty_o = (count == '0);
   assign full_o  = (count >= cap);
   assign head_o  = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_i) mem[wptr] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush_i) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_i) wptr <= wptr_nx;
         if (pop_i)  rptr <= rptr_nx;
         case ({push_i, pop_i})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      count <= cap || $past(deep_i) != deep_i) else $error("count above capacity"); // R4
   AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      full_o && !pop_i && !flush_i |=> !(count == '0 && $past(count) != '0)) else $error("full buffer lost data"); // R7
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> empty_o) else $error("flush left data"); // R9
endmodule

// File: rtl/rxq_status.sv
module rxq_status
   import rxq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush_i,
   input  logic            ovr_set_i,
   input  logic            irq_set_i,
   input  logic            irq_rd_clr_i,
   input  logic            clr_we_i,
   input  logic [CLR_W-1:0] clr_mask_i,
   output logic            overrun_o,
   output logic            rx_irq_o
);
   logic clr_ovr, clr_irq;

   assign clr_ovr = clr_we_i & clr_mask_i[CLR_OVR_BIT];
   assign clr_irq = (clr_we_i & clr_mask_i[CLR_IRQ_BIT]) | irq_rd_clr_i | flush_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun_o <= 1'b0;
         rx_irq_o  <= 1'b0;
      end else begin
         if (ovr_set_i)    overrun_o <= 1'b1;
         else if (clr_ovr) overrun_o <= 1'b0;
         if (irq_set_i)    rx_irq_o  <= 1'b1;
         else if (clr_irq) rx_irq_o  <= 1'b0;
      end
   end

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o && !clr_ovr |=> overrun_o) else $error("overrun not sticky"); // R7
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set_i |=> rx_irq_o) else $error("irq not raised"); // R8
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_mode_i,
   input  logic             rx_valid_i,
   input  logic [WIDTH-1:0] rx_byte_i,
   input  logic             rd_strobe_i,
   input  logic             clr_we_i,
   input  logic [1:0]       clr_mask_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic             empty_o,
   output logic             full_o,
   output logic             overrun_o,
   output logic             rx_irq_o
);
   logic             mode_q, flush, accept, pop;
   logic [WIDTH-1:0] head;

   assign flush  = (fifo_mode_i != mode_q);
   assign accept = rx_valid_i & ~full_o & ~flush;
   assign pop    = rd_strobe_i & ~empty_o & ~flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 1'b0;
         rd_data_o <= '0;
      end else begin
         mode_q <= fifo_mode_i;
         if (pop) rd_data_o <= head;
      end
   end

   rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush),
      .push_i  (accept),
      .pop_i   (pop),
      .deep_i  (mode_q),
      .din_i   (rx_byte_i),
      .head_o  (head),
      .empty_o (empty_o),
      .full_o  (full_o)
   );

   rxq_status u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (flush),
      .ovr_set_i    (rx_valid_i & full_o & ~flush),
      .irq_set_i    (accept & empty_o),
      .irq_rd_clr_i (pop & ~mode_q),
      .clr_we_i     (clr_we_i),
      .clr_mask_i   (clr_mask_i),
      .overrun_o    (overrun_o),
      .rx_irq_o     (rx_irq_o)
   );

   AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe_i && empty_o |=> $stable(rd_data_o)) else $error("empty read changed data"); // R10
   AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o)) else $error("full and empty together"); // R3
   AST_QUEUE_READ_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q && fifo_mode_i && rx_irq_o && !clr_we_i |=> rx_irq_o) else $error("queue read cleared irq"); // R6
endmodule

// File: tb/rxq_buffer_bench.sv
module rxq_buffer_bench;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_mode_i = 1'b0, rx_valid_i = 1'b0, rd_strobe_i = 1'b0, clr_we_i = 1'b0;
   logic [7:0] rx_byte_i = '0;
   logic [1:0] clr_mask_i = '0;
   logic [7:0] rd_data_o;
   logic       empty_o, full_o, overrun_o, rx_irq_o;

   int checks = 0, fails = 0, cycles = 0;

   // reference model
   logic [7:0] q[$];
   logic       m_mode = 1'b0, m_ovr = 1'b0, m_irq = 1'b0;
   logic [7:0] m_data = 8'h00;

   always #5 clk = ~clk;

   rxq_buffer u_rxq_buffer (
      .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i), .rx_valid_i(rx_valid_i),
      .rx_byte_i(rx_byte_i), .rd_strobe_i(rd_strobe_i), .clr_we_i(clr_we_i),
      .clr_mask_i(clr_mask_i), .rd_data_o(rd_data_o), .empty_o(empty_o),
      .full_o(full_o), .overrun_o(overrun_o), .rx_irq_o(rx_irq_o));

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, cycles);
      end
   endtask

   task automatic compare_all();
      int cap = m_mode ? DEPTH : 1;
      chk("R5 data", rd_data_o, m_data);
      chk("R3 empty", empty_o, q.size() == 0);
      chk("R4 full", full_o, q.size() >= cap);
      chk("R7 overrun", overrun_o, m_ovr);
      chk("R8 irq", rx_irq_o, m_irq);
   endtask

   task automatic model_step();
      int  cap = m_mode ? DEPTH : 1;
      bit  was_full = q.size() >= cap;
      bit  was_empty = q.size() == 0;
      bit  acc, pop, ovr_set, irq_set, irq_clr;
      acc = 0; pop = 0; ovr_set = 0; irq_set = 0; irq_clr = 0;
      if (fifo_mode_i != m_mode) begin
         q.delete();
         irq_clr = 1;
         m_mode = fifo_mode_i;
      end else begin
         pop     = rd_strobe_i && !was_empty;
         acc     = rx_valid_i && !was_full;
         ovr_set = rx_valid_i && was_full;
         irq_set = acc && was_empty;
         irq_clr = pop && !m_mode;
         if (pop) m_data = q.pop_front();
         if (acc) q.push_back(rx_byte_i);
      end
      if (clr_we_i && clr_mask_i[1]) irq_clr = 1;
      if (ovr_set) m_ovr = 1;
      else if (clr_we_i && clr_mask_i[0]) m_ovr = 0;
      if (irq_set) m_irq = 1;
      else if (irq_clr) m_irq = 0;
   endtask

   task automatic step(bit mode, bit rxv, logic [7:0] b, bit rd, bit cw, logic [1:0] cm);
      fifo_mode_i = mode; rx_valid_i = rxv; rx_byte_i = b; rd_strobe_i = rd;
      clr_we_i = cw; clr_mask_i = cm;
      model_step();
      @(posedge clk); #1;
      compare_all();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      bit mode;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 empty", empty_o, 1); chk("R1 full", full_o, 0);
      chk("R1 overrun", overrun_o, 0); chk("R1 irq", rx_irq_o, 0); chk("R1 data", rd_data_o, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // holding mode: one byte fills it (R4, R8)
      step(0, 1, 8'hA5, 0, 0, 2'b00);
      chk("R4 hold full", full_o, 1); chk("R8 irq on accept", rx_irq_o, 1);
      // second byte with a read in the same cycle is dropped (R7)
      step(0, 1, 8'h3C, 1, 0, 2'b00);
      chk("R7 overrun set", overrun_o, 1); chk("R6 read clears irq", rx_irq_o, 0);
      chk("R5 hold data", rd_data_o, 8'hA5); chk("R3 empty after read", empty_o, 1);
      // empty read keeps data (R10)
      step(0, 0, 8'h00, 1, 0, 2'b00);
      chk("R10 data kept", rd_data_o, 8'hA5); chk("R10 still empty", empty_o, 1);
      // clear overrun with bit 0 (R7)
      step(0, 0, 8'h00, 0, 1, 2'b01);
      chk("R7 overrun cleared", overrun_o, 0);
      // store a byte, then flip the mode with a strobe: flush (R9)
      step(0, 1, 8'h11, 0, 0, 2'b00);
      step(1, 1, 8'h22, 1, 0, 2'b00);
      chk("R9 flushed empty", empty_o, 1); chk("R9 irq cleared", rx_irq_o, 0);
      chk("R9 read ignored", rd_data_o, 8'hA5);

      // queue mode: 17 bytes, 16 kept (R2, R4, R7)
      for (int i = 0; i < 17; i++) step(1, 1, 8'(8'h40 + i), 0, 0, 2'b00);
      chk("R4 queue full", full_o, 1); chk("R7 queue overrun", overrun_o, 1);
      chk("R8 irq queue", rx_irq_o, 1);
      step(1, 1, 8'hEE, 1, 1, 2'b01); // pop + dropped push + clear: overrun wins (R7)
      chk("R7 set beats clear", overrun_o, 1);
      chk("R6 queue read keeps irq", rx_irq_o, 1);
      for (int i = 1; i < 16; i++) begin
         step(1, 0, 8'h00, 1, 0, 2'b00);
         chk("R2 order", rd_data_o, 8'h40 + i);
      end
      chk("R3 drained", empty_o, 1);
      step(1, 0, 8'h00, 0, 1, 2'b10);
      chk("R8 irq cleared by mask", rx_irq_o, 0);
      // simultaneous push and pop on one stored byte (R5)
      step(1, 1, 8'h77, 0, 0, 2'b00);
      step(1, 1, 8'h78, 1, 1, 2'b10); // irq set not expected: buffer not empty
      chk("R5 push+pop data", rd_data_o, 8'h77); chk("R3 one left", empty_o, 0);

      // random mix, compared every cycle
      mode = 1;
      for (int n = 0; n < 4000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[9:0] == 10'h155) mode = ~mode;
         step(mode, lfsr[0] | lfsr[5], lfsr[15:8], lfsr[2] & lfsr[7], lfsr[3] & lfsr[4] & lfsr[11],
              lfsr[6:5]);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule